// File: doc/BRIEF.md
# Conditional Branch and Next-PC Unit

This block decides, once per instruction, whether control flow leaves the sequential path. It combines a four-bit condition selector with the flags of the ALU result computed by the same instruction (sign, zero, least significant bit, carry-out) and with the stored carry flag. It then picks the following program counter: the incremented current value, or the target carried in the instruction's B field. Because the test reads the result of the instruction being executed, a compare-and-branch or an increment-and-branch finishes in one cycle.

The unit holds the program counter register. The register advances only on cycles where the sequencer marks an instruction as complete. The unit also presents the return address (current PC plus one) for subroutine calls, which the datapath writes to memory. ALU arithmetic, carry register updates and memory writes are done outside the block.

Top module: `brnpc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is RESET_PC (default 0). After release it stays there until the first step.
- R2: With `jmp_en_i` low, `taken_o` is 0 whatever the condition and flags, and `next_pc_o` is `pc_o`+1, wrapping from 255 to 0.
- R3: With `parity_i` low, the branch term is the OR of the terms enabled in `cond_i[2:0]`. Bit 0 enables result sign, bit 1 enables result zero, bit 2 enables "carry clear". So code 1 is negative, 2 is zero, 3 is negative-or-zero, 4 is carry clear, and 6 is carry-clear-or-zero.
- R4: `cond_i[3]` inverts the branch term. Codes 9, A, B, C and E take the branch exactly when codes 1, 2, 3, 4 and 6 would not.
- R5: Code 0 never branches. Code 8 always branches, which is the unconditional jump and the subroutine call.
- R6: With `parity_i` high, the term is the result's bit 0 and `cond_i[2:0]` is ignored. Code 2 then branches on odd and code A on even.
- R7: `carry_src_i` low makes the carry term use `carry_q_i`; high makes it use the ALU carry-out `res_cout_i`. An increment-and-branch with code 4 and source 1 branches unless the incremented value was 255 (carry-out 1), and code C branches only then.
- R8: When `taken_o` is 1, `next_pc_o` equals `b_field_i`; otherwise it equals `pc_o`+1.
- R9: At a clock edge with `step_i` high, `pc_o` loads `next_pc_o`. With `step_i` low it holds.
- R10: `link_o` is `pc_o`+1 modulo 256, independent of the branch decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_i | input | 1 | Instruction completes this cycle |
| jmp_en_i | input | 1 | Instruction is a branch type |
| cond_i | input | 4 | Condition selector: [2:0] term enables, [3] invert |
| parity_i | input | 1 | Test result bit 0 instead of the OR terms |
| carry_src_i | input | 1 | Carry term source: 0 stored flag, 1 ALU carry-out |
| res_sign_i | input | 1 | ALU result bit 7 |
| res_zero_i | input | 1 | ALU result is zero |
| res_lsb_i | input | 1 | ALU result bit 0 |
| res_cout_i | input | 1 | ALU carry-out |
| carry_q_i | input | 1 | Stored carry flag |
| b_field_i | input | 8 | Branch target from the instruction |
| pc_o | output | 8 | Current program counter |
| next_pc_o | output | 8 | Selected following program counter |
| link_o | output | 8 | Return address for calls |
| taken_o | output | 1 | Branch taken |

## Verification
The hardest case to reach from the ports is the PC wrap-around: `pc_o` must sit at 255 while a non-taken instruction steps. The bench gets there with an unconditional jump to 255 and then one sequential step. The same placement is used to check `link_o` at the boundary. Increment-and-branch at the 255 edge is reached by driving the carry-out source with the carry-out set and the stored carry set to the opposite value. This shows which flag the decision reads.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;

   localparam int COND_W   = 4;
   localparam int CB_SIGN  = 0;
   localparam int CB_ZERO  = 1;
   localparam int CB_NOTC  = 2;
   localparam int CB_INV   = 3;

   typedef struct packed {
      logic sign;
      logic zero;
      logic lsb;
      logic cout;
   } res_flags_t;

   typedef enum logic {
      CSRC_STORED = 1'b0,
      CSRC_ALU    = 1'b1
   } carry_src_e;

endpackage

// File: rtl/brnpc_cond.sv
module brnpc_cond
   import brnpc_pkg::*;
#(
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 jmp_en,
   input  logic [COND_W-1:0]    cond,
   input  logic                 parity,
   input  carry_src_e           csrc,
   input  res_flags_t           flags,
   input  logic                 carry_q,
   output logic                 taken
);

   logic carry_sel;
   logic or_term;
   logic term;

   always_comb begin
      carry_sel = (csrc == CSRC_ALU) ? flags.cout : carry_q;
      or_term   = (cond[CB_SIGN] & flags.sign)
                | (cond[CB_ZERO] & flags.zero)
                | (cond[CB_NOTC] & ~carry_sel);
   end

   generate
      if (PARITY_EN) begin : g_parity
         always_comb term = parity ? flags.lsb : or_term;
      end else begin : g_no_parity
         always_comb term = or_term;
      end
   endgenerate

   always_comb taken = jmp_en & (term ^ cond[CB_INV]);

   // R2: non-branch instructions never divert flow
   p_nojmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !jmp_en |-> !taken);

   // R5: code 0 never, code 8 always
   p_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_en && !parity && cond == 4'h0) |-> !taken);
   p_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_en && !parity && cond == 4'h8) |-> taken);

   // R6: parity mode follows bit 0 only
   p_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_en && parity && cond == 4'h2) |-> (taken == flags.lsb));

endmodule

// File: rtl/brnpc_sel.sv
module brnpc_sel #(
   parameter int PC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pc_q,
   input  logic [PC_W-1:0] target,
   input  logic            taken,
   output logic [PC_W-1:0] next_pc,
   output logic [PC_W-1:0] link
);

   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   logic [PC_W-1:0] seq_pc;

   always_comb begin
      seq_pc  = pc_q + ONE;
      link    = seq_pc;
      next_pc = taken ? target : seq_pc;
   end

   // R8: taken path picks the target
   p_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (next_pc == target));

   // R10: link tracks PC+1 regardless of branch
   p_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q == {PC_W{1'b1}}) |-> (link == '0));

endmodule

// File: rtl/brnpc_reg.sv
module brnpc_reg #(
   parameter int PC_W     = 8,
   parameter int RESET_PC = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [PC_W-1:0] next_pc,
   output logic [PC_W-1:0] pc_q
);

   localparam logic [PC_W-1:0] RST_VAL = PC_W'(RESET_PC);

   logic primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= RST_VAL;
         primed_q <= 1'b0;
      end else begin
         primed_q <= 1'b1;
         if (step) pc_q <= next_pc;
      end
   end

   // R9: load on step, hold otherwise
   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && step) |=> (pc_q == $past(next_pc)));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !step) |=> $stable(pc_q));

   // R1: reset value held until first step
   p_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!primed_q) |-> (pc_q == RST_VAL));

endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
   import brnpc_pkg::*;
#(
   parameter int PC_W      = 8,
   parameter int RESET_PC  = 0,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_i,
   input  logic            jmp_en_i,
   input  logic [3:0]      cond_i,
   input  logic            parity_i,
   input  logic            carry_src_i,
   input  logic            res_sign_i,
   input  logic            res_zero_i,
   input  logic            res_lsb_i,
   input  logic            res_cout_i,
   input  logic            carry_q_i,
   input  logic [PC_W-1:0] b_field_i,
   output logic [PC_W-1:0] pc_o,
   output logic [PC_W-1:0] next_pc_o,
   output logic [PC_W-1:0] link_o,
   output logic            taken_o
);

   generate
      if (PC_W < 2) begin : g_bad_width
         $error("brnpc_unit: PC_W must be at least 2");
      end
      if (RESET_PC < 0 || RESET_PC >= (1 << PC_W)) begin : g_bad_reset
         $error("brnpc_unit: RESET_PC out of range");
      end
   endgenerate

   res_flags_t flags;
   carry_src_e csrc;
   logic       taken;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] next_pc;
   logic [PC_W-1:0] link;

   always_comb begin
      flags.sign = res_sign_i;
      flags.zero = res_zero_i;
      flags.lsb  = res_lsb_i;
      flags.cout = res_cout_i;
      csrc       = carry_src_e'(carry_src_i);
   end

   brnpc_cond #(.PARITY_EN(PARITY_EN)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .jmp_en  (jmp_en_i),
      .cond    (cond_i),
      .parity  (parity_i),
      .csrc    (csrc),
      .flags   (flags),
      .carry_q (carry_q_i),
      .taken   (taken)
   );

   brnpc_sel #(.PC_W(PC_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .pc_q    (pc_q),
      .target  (b_field_i),
      .taken   (taken),
      .next_pc (next_pc),
      .link    (link)
   );

   brnpc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step_i),
      .next_pc (next_pc),
      .pc_q    (pc_q)
   );

   assign pc_o      = pc_q;
   assign next_pc_o = next_pc;
   assign link_o    = link;
   assign taken_o   = taken;

   // R7: increment-and-branch reads the ALU carry-out, not the stored flag
   p_cout_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_en_i && !parity_i && cond_i == 4'h4 && carry_src_i) |-> (taken_o == !res_cout_i));

endmodule

// File: tb/brnpc_unit_tb.sv
module brnpc_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 0, jmp_en_i = 0, parity_i = 0, carry_src_i = 0;
   logic [3:0] cond_i = 0;
   logic       res_sign_i = 0, res_zero_i = 0, res_lsb_i = 0, res_cout_i = 0, carry_q_i = 0;
   logic [7:0] b_field_i = 0;
   logic [7:0] pc_o, next_pc_o, link_o;
   logic       taken_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   brnpc_unit dut_i (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .jmp_en_i(jmp_en_i),
      .cond_i(cond_i), .parity_i(parity_i), .carry_src_i(carry_src_i),
      .res_sign_i(res_sign_i), .res_zero_i(res_zero_i), .res_lsb_i(res_lsb_i),
      .res_cout_i(res_cout_i), .carry_q_i(carry_q_i), .b_field_i(b_field_i),
      .pc_o(pc_o), .next_pc_o(next_pc_o), .link_o(link_o), .taken_o(taken_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // drive a branch decision away from the edge and check taken + next PC
   task automatic probe(input string req, input logic j, input logic [3:0] c,
                        input logic par, input logic src, input logic s,
                        input logic z, input logic l, input logic co,
                        input logic cq, input logic exp_t);
      @(negedge clk);
      jmp_en_i = j; cond_i = c; parity_i = par; carry_src_i = src;
      res_sign_i = s; res_zero_i = z; res_lsb_i = l; res_cout_i = co; carry_q_i = cq;
      b_field_i = 8'h5A;
      #1;
      chk(req, taken_o, exp_t);
      chk({req, " next"}, next_pc_o, exp_t ? 8'h5A : 8'(pc_o + 8'd1));
   endtask

   task automatic jump_to(input logic [7:0] a);
      @(negedge clk);
      jmp_en_i = 1; cond_i = 4'h8; parity_i = 0; b_field_i = a; step_i = 1;
      @(posedge clk); #1;
      step_i = 0; jmp_en_i = 0;
   endtask

   task automatic t_reset;
      chk("R1 reset pc", pc_o, 0);
      repeat (2) @(posedge clk);
      #1 chk("R1 hold until step", pc_o, 0);
   endtask

   task automatic t_nojmp;
      probe("R2 no jump code8", 0, 4'h8, 0, 0, 1, 1, 1, 0, 0, 0);
      probe("R2 no jump zero", 0, 4'h2, 0, 0, 0, 1, 0, 0, 0, 0);
   endtask

   task automatic t_or_terms;
      probe("R3 neg sign", 1, 4'h1, 0, 0, 1, 0, 0, 0, 1, 1);
      probe("R3 neg pos",  1, 4'h1, 0, 0, 0, 0, 0, 0, 1, 0);
      probe("R3 zero yes", 1, 4'h2, 0, 0, 0, 1, 0, 0, 1, 1);
      probe("R3 zero no",  1, 4'h2, 0, 0, 1, 0, 0, 0, 1, 0);
      probe("R3 le zero",  1, 4'h3, 0, 0, 0, 1, 0, 0, 1, 1);
      probe("R3 le neg",   1, 4'h3, 0, 0, 1, 0, 0, 0, 1, 1);
      probe("R3 le pos",   1, 4'h3, 0, 0, 0, 0, 0, 0, 1, 0);
      probe("R3 cc clear", 1, 4'h4, 0, 0, 0, 0, 0, 1, 0, 1);
      probe("R3 cc set",   1, 4'h4, 0, 0, 0, 0, 0, 0, 1, 0);
      probe("R3 ls zero",  1, 4'h6, 0, 0, 0, 1, 0, 0, 1, 1);
      probe("R3 ls hi",    1, 4'h6, 0, 0, 0, 0, 0, 0, 1, 0);
   endtask

   task automatic t_invert;
      probe("R4 pl sign",  1, 4'h9, 0, 0, 1, 0, 0, 0, 0, 0);
      probe("R4 pl pos",   1, 4'h9, 0, 0, 0, 0, 0, 0, 0, 1);
      probe("R4 ne zero",  1, 4'hA, 0, 0, 0, 1, 0, 0, 0, 0);
      probe("R4 ne val",   1, 4'hA, 0, 0, 0, 0, 0, 0, 0, 1);
      probe("R4 gt pos",   1, 4'hB, 0, 0, 0, 0, 0, 0, 0, 1);
      probe("R4 gt zero",  1, 4'hB, 0, 0, 0, 1, 0, 0, 0, 0);
      probe("R4 cs set",   1, 4'hC, 0, 0, 0, 0, 0, 0, 1, 1);
      probe("R4 hi",       1, 4'hE, 0, 0, 0, 0, 0, 0, 1, 1);
      probe("R4 hi zero",  1, 4'hE, 0, 0, 0, 1, 0, 0, 1, 0);
   endtask

   task automatic t_never_always;
      probe("R5 never", 1, 4'h0, 0, 0, 1, 1, 1, 0, 0, 0);
      probe("R5 always", 1, 4'h8, 0, 0, 1, 1, 1, 1, 1, 1);
   endtask

   task automatic t_parity;
      probe("R6 odd yes",  1, 4'h2, 1, 0, 0, 0, 1, 0, 0, 1);
      probe("R6 odd no",   1, 4'h2, 1, 0, 1, 1, 0, 0, 0, 0);
      probe("R6 even yes", 1, 4'hA, 1, 0, 1, 1, 0, 0, 0, 1);
      probe("R6 even no",  1, 4'hA, 1, 0, 0, 0, 1, 0, 0, 0);
      probe("R6 sel ign",  1, 4'h7, 1, 0, 1, 1, 0, 0, 0, 0);
   endtask

   task automatic t_incj;
      probe("R7 incjne mid", 1, 4'h4, 0, 1, 0, 0, 0, 0, 1, 1);
      probe("R7 incjne 255", 1, 4'h4, 0, 1, 0, 1, 0, 1, 0, 0);
      probe("R7 incjeq 255", 1, 4'hC, 0, 1, 0, 1, 0, 1, 0, 1);
      probe("R7 incjeq mid", 1, 4'hC, 0, 1, 0, 0, 0, 0, 1, 0);
   endtask

   task automatic t_pc_flow;
      jump_to(8'h40);
      chk("R9 R8 jump load", pc_o, 8'h40);
      chk("R10 link", link_o, 8'h41);
      @(negedge clk); jmp_en_i = 0; step_i = 0;
      @(posedge clk); #1;
      chk("R9 hold", pc_o, 8'h40);
      @(negedge clk); step_i = 1;
      @(posedge clk); #1; step_i = 0;
      chk("R9 seq step", pc_o, 8'h41);
      jump_to(8'hFF);
      chk("R10 link wrap", link_o, 8'h00);
      #1 chk("R2 next wrap", next_pc_o, 8'h00);
      @(negedge clk); step_i = 1;
      @(posedge clk); #1; step_i = 0;
      chk("R9 R2 pc wrap", pc_o, 8'h00);
      // call: code 8 takes target, link still PC+1
      @(negedge clk); jmp_en_i = 1; cond_i = 4'h8; b_field_i = 8'h90; #1;
      chk("R10 link on call", link_o, 8'h01);
      chk("R8 call target", next_pc_o, 8'h90);
      jmp_en_i = 0;
   endtask

   initial begin
      #1 chk("R1 in reset", pc_o, 0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      t_reset();
      t_nojmp();
      t_or_terms();
      t_invert();
      t_never_always();
      t_parity();
      t_incj();
      t_pc_flow();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule